// File: doc/BRIEF.md
# Block-Transfer Byte DMA Controller

This block is a single-channel engine that copies a block of bytes from one endpoint to another inside an 8-bit microcontroller subsystem. Each endpoint is a peripheral byte stream (two serial ports, a two-wire bus, SPI, an ADC result source, a CRC sink) or the on-chip RAM byte port. A configuration byte picks the source and the destination. Software arms the channel through a small register port, and one pulse on the trigger input then runs a whole block.

The block length is held in a 16-bit current-count register that counts up once per moved byte and ends the block when it rolls over from FFFF to 0000. On that rollover the arm bit drops, a sticky completion flag rises, the current count is reloaded from a base register and the RAM address pointer is reloaded from its own reload register. The channel is then ready for the next trigger without any software rewrite.

The peripheral ports use valid/ready. A source byte is taken only in a cycle where the selected `rx_valid` and `rx_ready` are both high. A destination byte sits on `tx_data` with the selected `tx_valid` held high and unchanged until `tx_ready` is seen. Either side may stall for any number of cycles. The RAM port is never stalled. It has synchronous reads with one cycle of latency.

Top module: `byte_dma`

## Requirements
- R1: The configuration register (address 0) holds the source code in bits [7:4] and the destination code in bits [3:0]. Source codes 0001, 0010, 0101, 0111 and 1001 select peripheral inputs 0 to 4 (serial-0, serial-1, two-wire, SPI, ADC). Destination codes 0001, 0010, 0101, 0111 and 1101 select peripheral outputs 0 to 4 (serial-0, serial-1, two-wire, SPI, CRC). Code 1111 selects RAM on either side.
- R2: The control register (address 1) reads {5'b0, busy, done, arm}, and writing bit 0 sets or clears arm. A trigger pulse starts a block only while arm is set and the channel is idle. Without arm the trigger has no effect.
- R3: Any other code (0000 disabled, or reserved), or RAM selected as both source and destination, blocks the start. The trigger is then ignored: no handshake strobe and no RAM access occur, and the registers keep their values.
- R4: Each transaction moves exactly one byte, unmodified, and bytes reach the destination in the order they left the source.
- R5: A source byte is taken only on `rx_valid` and `rx_ready` high together. `tx_valid` and `tx_data` stay stable until `tx_ready` is high.
- R6: The current count (addresses 2 low, 3 high) increments after every transaction, and a block performs 65536 minus the starting count transactions. A starting count of FFFF gives exactly one.
- R7: On the FFFF-to-0000 rollover, arm is cleared and done is set. The current count is loaded from the base register (addresses 4, 5), and the pointer is loaded from the reload register (addresses 8, 9).
- R8: The RAM pointer (addresses 6, 7) supplies `ram_addr` and increments after each RAM read or write. RAM read data is taken one cycle after the read strobe.
- R9: The done flag, which is also driven on `done_flag`, stays set until a write to the control register with bit 1 high.
- R10: While busy, writes to the configuration, count, base, pointer and reload registers and to the arm bit are ignored.
- R11: At most one `rx_ready` bit and one `tx_valid` bit are high at a time, and only the ones for the selected endpoints.
- R12: Reset clears every register, the done flag and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| trigger | input | 1 | Block start pulse |
| done_flag | output | 1 | Sticky block-complete flag |
| rx_valid | input | 5 | Per-source byte valid |
| rx_data | input | 40 | Per-source byte, source i in bits [8i+7:8i] |
| rx_ready | output | 5 | Per-source byte accept |
| tx_valid | output | 5 | Per-destination byte valid |
| tx_data | output | 8 | Byte offered to the destination |
| tx_ready | input | 5 | Per-destination byte accept |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write when high, read when low |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after a read |

## Verification
A corrupted count shows up as a block that takes the wrong number of bytes. The first sign is a source byte that is still queued, or an extra byte consumed, when done rises, or a reload value that is wrong when the count is read back. A pointer fault shows on `ram_addr` in the very cycle of the first wrong access. A fault in the routing or the holding register shows on the first delivered byte, or as a strobe on an endpoint that was not selected, and the bench checks both of these on every clock.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  localparam int NPORT = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_GET, ST_RWAIT, ST_PUT} bdma_state_e;

  typedef struct packed {
    logic       ok;
    logic       ram;
    logic [2:0] idx;
  } bdma_route_t;

  function automatic bdma_route_t src_route(input logic [3:0] code);
    bdma_route_t r;
    r = '0;
    case (code)
      4'b0001: begin r.ok = 1'b1; r.idx = 3'd0; end
      4'b0010: begin r.ok = 1'b1; r.idx = 3'd1; end
      4'b0101: begin r.ok = 1'b1; r.idx = 3'd2; end
      4'b0111: begin r.ok = 1'b1; r.idx = 3'd3; end
      4'b1001: begin r.ok = 1'b1; r.idx = 3'd4; end
      4'b1111: begin r.ok = 1'b1; r.ram = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic bdma_route_t dst_route(input logic [3:0] code);
    bdma_route_t r;
    r = '0;
    case (code)
      4'b0001: begin r.ok = 1'b1; r.idx = 3'd0; end
      4'b0010: begin r.ok = 1'b1; r.idx = 3'd1; end
      4'b0101: begin r.ok = 1'b1; r.idx = 3'd2; end
      4'b0111: begin r.ok = 1'b1; r.idx = 3'd3; end
      4'b1101: begin r.ok = 1'b1; r.idx = 3'd4; end
      4'b1111: begin r.ok = 1'b1; r.ram = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bdma_route.sv
module bdma_route
  import bdma_pkg::*;
#(
  parameter int NP = NPORT
) (
  input  logic [7:0]    cfg,
  output logic [NP-1:0] src_mask,
  output logic [NP-1:0] dst_mask,
  output logic          src_ram,
  output logic          dst_ram,
  output logic          cfg_ok
);
  bdma_route_t s_rt, d_rt;

  assign s_rt    = src_route(cfg[7:4]);
  assign d_rt    = dst_route(cfg[3:0]);
  assign src_ram = s_rt.ok & s_rt.ram;
  assign dst_ram = d_rt.ok & d_rt.ram;
  // R3: both codes legal and not a RAM-to-RAM pair
  assign cfg_ok  = s_rt.ok & d_rt.ok & ~(s_rt.ram & d_rt.ram);

  for (genvar i = 0; i < NP; i++) begin : g_mask
    assign src_mask[i] = s_rt.ok & ~s_rt.ram & (s_rt.idx == 3'(i));
    assign dst_mask[i] = d_rt.ok & ~d_rt.ram & (d_rt.idx == 3'(i));
  end
endmodule

// File: rtl/bdma_regs.sv
module bdma_regs #(
  parameter int CW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [3:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          busy,
  input  logic          step_cnt,
  input  logic          step_ptr,
  output logic [7:0]    cfg,
  output logic          arm,
  output logic          done,
  output logic          cnt_last,
  output logic [AW-1:0] ptr
);
  localparam int CH = CW - 8;
  localparam int AH = AW - 8;

  logic [CW-1:0] cnt, base;
  logic [AW-1:0] reload;
  logic          wr_ok, wrap, clr_done;

  assign wr_ok    = we & ~busy;
  assign cnt_last = &cnt;
  assign wrap     = step_cnt & cnt_last;
  assign clr_done = we & (addr == 4'd1) & wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; arm <= 1'b0; done <= 1'b0;
      cnt <= '0; base <= '0; ptr <= '0; reload <= '0;
    end else begin
      if (wrap) begin
        cnt  <= base;
        ptr  <= reload;
        arm  <= 1'b0;
        done <= 1'b1;
      end else begin
        if (step_cnt) cnt <= cnt + 1'b1;
        if (step_ptr) ptr <= ptr + 1'b1;
        if (clr_done) done <= 1'b0;
      end
      if (wr_ok) begin
        case (addr)
          4'd0: cfg           <= wdata;
          4'd1: arm           <= wdata[0];
          4'd2: cnt[7:0]      <= wdata;
          4'd3: cnt[CW-1:8]   <= wdata[CH-1:0];
          4'd4: base[7:0]     <= wdata;
          4'd5: base[CW-1:8]  <= wdata[CH-1:0];
          4'd6: ptr[7:0]      <= wdata;
          4'd7: ptr[AW-1:8]   <= wdata[AH-1:0];
          4'd8: reload[7:0]   <= wdata;
          4'd9: reload[AW-1:8] <= wdata[AH-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = cfg;
      4'd1:    rdata = {5'b0, busy, done, arm};
      4'd2:    rdata = cnt[7:0];
      4'd3:    rdata = 8'(cnt[CW-1:8]);
      4'd4:    rdata = base[7:0];
      4'd5:    rdata = 8'(base[CW-1:8]);
      4'd6:    rdata = ptr[7:0];
      4'd7:    rdata = 8'(ptr[AW-1:8]);
      4'd8:    rdata = reload[7:0];
      4'd9:    rdata = 8'(reload[AW-1:8]);
      default: rdata = 8'h00;
    endcase
  end

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == $past(base) && ptr == $past(reload) && !arm && done)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cnt && !cnt_last) |=> cnt == CW'($past(cnt) + 1'b1)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_done) |=> done); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we && addr == 4'd0) |=> cfg == $past(cfg)); // R10
endmodule

// File: rtl/bdma_engine.sv
module bdma_engine
  import bdma_pkg::*;
#(
  parameter int NP = NPORT,
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trigger,
  input  logic            arm,
  input  logic            cfg_ok,
  input  logic [NP-1:0]   src_mask,
  input  logic [NP-1:0]   dst_mask,
  input  logic            src_ram,
  input  logic            dst_ram,
  input  logic            cnt_last,
  input  logic [AW-1:0]   ptr,
  input  logic [NP-1:0]   rx_valid,
  input  logic [NP*DW-1:0] rx_data,
  output logic [NP-1:0]   rx_ready,
  output logic [NP-1:0]   tx_valid,
  output logic [DW-1:0]   tx_data,
  input  logic [NP-1:0]   tx_ready,
  output logic            ram_en,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  input  logic [DW-1:0]   ram_rdata,
  output logic            step_cnt,
  output logic            step_ptr,
  output logic            busy
);
  bdma_state_e st, st_nxt;
  logic [DW-1:0] hold_q, src_byte;
  logic          take_rx, take_ram;

  always_comb begin
    src_byte = '0;
    for (int i = 0; i < NP; i++)
      if (src_mask[i]) src_byte = rx_data[i*DW +: DW];
  end

  always_comb begin
    st_nxt   = st;
    rx_ready = '0;
    tx_valid = '0;
    ram_en   = 1'b0;
    ram_we   = 1'b0;
    step_cnt = 1'b0;
    step_ptr = 1'b0;
    take_rx  = 1'b0;
    take_ram = 1'b0;
    case (st)
      ST_IDLE: if (trigger && arm && cfg_ok) st_nxt = ST_GET;
      ST_GET: begin
        if (src_ram) begin
          ram_en   = 1'b1;
          step_ptr = 1'b1;
          st_nxt   = ST_RWAIT;
        end else begin
          rx_ready = src_mask;
          if (|(src_mask & rx_valid)) begin
            take_rx = 1'b1;
            st_nxt  = ST_PUT;
          end
        end
      end
      ST_RWAIT: begin
        take_ram = 1'b1;
        st_nxt   = ST_PUT;
      end
      ST_PUT: begin
        if (dst_ram) begin
          ram_en   = 1'b1;
          ram_we   = 1'b1;
          step_ptr = 1'b1;
          step_cnt = 1'b1;
        end else begin
          tx_valid = dst_mask;
          step_cnt = |(dst_mask & tx_ready);
        end
        if (step_cnt) st_nxt = cnt_last ? ST_IDLE : ST_GET;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      hold_q <= '0;
    end else begin
      st <= st_nxt;
      if (take_rx)       hold_q <= src_byte;
      else if (take_ram) hold_q <= ram_rdata;
    end
  end

  assign busy      = (st != ST_IDLE);
  assign tx_data   = hold_q;
  assign ram_wdata = hold_q;
  assign ram_addr  = ptr;

  AST_ONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_ready) && ((rx_ready & ~src_mask) == '0)); // R11
  AST_ONE_DST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_valid) && ((tx_valid & ~dst_mask) == '0)); // R11
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tx_valid & ~tx_ready)) |=> ($stable(tx_valid) && $stable(tx_data))); // R5
  AST_RAM_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |=> !ram_en); // R8
endmodule

// File: rtl/byte_dma.sv
module byte_dma
  import bdma_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [3:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               trigger,
  output logic               done_flag,
  input  logic [NPORT-1:0]   rx_valid,
  input  logic [NPORT*DW-1:0] rx_data,
  output logic [NPORT-1:0]   rx_ready,
  output logic [NPORT-1:0]   tx_valid,
  output logic [DW-1:0]      tx_data,
  input  logic [NPORT-1:0]   tx_ready,
  output logic               ram_en,
  output logic               ram_we,
  output logic [AW-1:0]      ram_addr,
  output logic [DW-1:0]      ram_wdata,
  input  logic [DW-1:0]      ram_rdata
);
  logic [7:0]       cfg;
  logic             arm, busy, cnt_last, step_cnt, step_ptr;
  logic             src_ram, dst_ram, cfg_ok;
  logic [NPORT-1:0] src_mask, dst_mask;
  logic [AW-1:0]    ptr;

  bdma_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .step_cnt(step_cnt), .step_ptr(step_ptr),
    .cfg(cfg), .arm(arm), .done(done_flag), .cnt_last(cnt_last), .ptr(ptr)
  );

  bdma_route #(.NP(NPORT)) u_route (
    .cfg(cfg), .src_mask(src_mask), .dst_mask(dst_mask),
    .src_ram(src_ram), .dst_ram(dst_ram), .cfg_ok(cfg_ok)
  );

  bdma_engine #(.NP(NPORT), .DW(DW), .AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .arm(arm), .cfg_ok(cfg_ok),
    .src_mask(src_mask), .dst_mask(dst_mask), .src_ram(src_ram), .dst_ram(dst_ram),
    .cnt_last(cnt_last), .ptr(ptr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .step_cnt(step_cnt), .step_ptr(step_ptr), .busy(busy)
  );

  AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(arm && trigger)); // R2
endmodule

// File: tb/byte_dma_tb.sv
`timescale 1ns/1ps
module byte_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        trigger = 1'b0;
  logic        done_flag;
  logic [4:0]  rx_valid = '0;
  logic [39:0] rx_data = '0;
  logic [4:0]  rx_ready;
  logic [4:0]  tx_valid;
  logic [7:0]  tx_data;
  logic [4:0]  tx_ready = '0;
  logic        ram_en, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;

  byte_dma u_dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0]  srcq [5][$];
  logic [7:0]  expq [$];
  logic [7:0]  mem [int];
  logic [4:0]  src_allow = '0, dst_allow = '0;
  logic        ram_allow = 1'b0, stall = 1'b0;
  logic [15:0] exp_ptr = '0;
  logic        rd_pend = 1'b0, hold_pend = 1'b0;
  logic [15:0] rd_addr;
  logic [4:0]  hold_v;
  logic [7:0]  hold_d;
  logic [7:0]  rv;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural endpoint models and per-clock reference comparison
  initial begin
    forever begin
      @(negedge clk);
      if (rd_pend) begin
        ram_rdata = mem.exists(int'(rd_addr)) ? mem[int'(rd_addr)] : 8'h00;
        rd_pend = 1'b0;
      end
      cyc++;
      for (int i = 0; i < 5; i++) begin
        rx_valid[i] = (srcq[i].size() > 0) && !(stall && (cyc % 3 == 0));
        rx_data[i*8 +: 8] = (srcq[i].size() > 0) ? srcq[i][0] : 8'h00;
      end
      tx_ready = (stall && (cyc % 2 == 0)) ? 5'b0 : 5'h1f;
      #1;
      if (!rst_n) continue;
      chk(((rx_ready & ~src_allow) == 0) && ((tx_valid & ~dst_allow) == 0) &&
          $countones(rx_ready) <= 1 && $countones(tx_valid) <= 1 && (!ram_en || ram_allow),
          "R11 strobes", {rx_ready, tx_valid, 3'b0, ram_en}, {src_allow, dst_allow, 3'b0, ram_allow});
      if (hold_pend)
        chk(tx_valid == hold_v && tx_data == hold_d, "R5 hold", {tx_valid, tx_data}, {hold_v, hold_d});
      hold_pend = |(tx_valid & ~tx_ready);
      hold_v = tx_valid;
      hold_d = tx_data;
      for (int i = 0; i < 5; i++)
        if (rx_valid[i] && rx_ready[i]) expq.push_back(srcq[i].pop_front());
      if (|(tx_valid & tx_ready)) begin
        if (expq.size() == 0) chk(1'b0, "R4 extra tx byte", tx_data, 0);
        else begin
          rv = expq.pop_front();
          chk(tx_data == rv, "R4 tx data", tx_data, rv);
        end
      end
      if (ram_en) begin
        chk(ram_addr == exp_ptr, "R8 ram addr", ram_addr, exp_ptr);
        if (ram_we) begin
          if (expq.size() == 0) chk(1'b0, "R4 extra ram byte", ram_wdata, 0);
          else begin
            rv = expq.pop_front();
            chk(ram_wdata == rv, "R4 ram data", ram_wdata, rv);
          end
          mem[int'(ram_addr)] = ram_wdata;
        end else begin
          expq.push_back(mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00);
          rd_pend = 1'b1;
          rd_addr = ram_addr;
        end
        exp_ptr = exp_ptr + 16'd1;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
    logic [7:0] d;
    rd(a, d);
    chk(d == e, tag, d, e);
  endtask

  task automatic fire();
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done_flag && n < 3000) begin @(negedge clk); n++; end
    chk(done_flag, tag, done_flag, 1);
  endtask

  task automatic setup(input logic [7:0] cfgv, input logic [15:0] cnt, input logic [15:0] base,
                       input logic [15:0] ptr, input logic [15:0] rel);
    wr(4'd2, cnt[7:0]);  wr(4'd3, cnt[15:8]);
    wr(4'd4, base[7:0]); wr(4'd5, base[15:8]);
    wr(4'd6, ptr[7:0]);  wr(4'd7, ptr[15:8]);
    wr(4'd8, rel[7:0]);  wr(4'd9, rel[15:8]);
    wr(4'd0, cfgv);
    exp_ptr = ptr;
  endtask

  task automatic flush();
    for (int i = 0; i < 5; i++) srcq[i].delete();
    expq.delete();
    src_allow = '0; dst_allow = '0; ram_allow = 1'b0; stall = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    total++; bad++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    for (int a = 0; a < 10; a++) expect_reg(4'(a), 8'h00, "R12 reset reg");
    chk(done_flag == 1'b0 && rx_ready == 0 && tx_valid == 0 && !ram_en, "R12 reset outputs",
        {done_flag, rx_ready, tx_valid, ram_en}, 0);

    // serial-0 RX -> RAM, four bytes, stalls, config frozen while busy
    setup(8'h1F, 16'hFFFC, 16'hFFFE, 16'h0100, 16'h0200);
    expect_reg(4'd0, 8'h1F, "R1 config readback");
    src_allow = 5'b00001; ram_allow = 1'b1; stall = 1'b1;
    wr(4'd1, 8'h01);
    fire();
    repeat (2) @(negedge clk);
    expect_reg(4'd1, 8'h05, "R2 busy after armed trigger");
    wr(4'd0, 8'h00); wr(4'd2, 8'h00); wr(4'd1, 8'h00);
    expect_reg(4'd0, 8'h1F, "R10 config write ignored");
    expect_reg(4'd2, 8'hFC, "R10 count write ignored");
    expect_reg(4'd1, 8'h05, "R10 arm write ignored");
    srcq[0].push_back(8'hA1); srcq[0].push_back(8'hB2);
    srcq[0].push_back(8'hC3); srcq[0].push_back(8'hD4);
    wait_done("R7 done after four bytes");
    expect_reg(4'd1, 8'h02, "R7 arm cleared done set");
    expect_reg(4'd2, 8'hFE, "R7 count reloaded lo");
    expect_reg(4'd3, 8'hFF, "R7 count reloaded hi");
    expect_reg(4'd6, 8'h00, "R7 pointer reloaded lo");
    expect_reg(4'd7, 8'h02, "R7 pointer reloaded hi");
    chk(mem[32'h103] == 8'hD4 && mem[32'h100] == 8'hA1, "R8 ram placement", mem[32'h103], 8'hD4);
    chk(srcq[0].size() == 0 && expq.size() == 0, "R6 four transactions", srcq[0].size(), 0);
    repeat (5) @(negedge clk);
    chk(done_flag, "R9 done sticky", done_flag, 1);
    wr(4'd1, 8'h00);
    chk(done_flag, "R9 done kept on bit1=0", done_flag, 1);
    wr(4'd1, 8'h02);
    #2 chk(!done_flag, "R9 done cleared", done_flag, 0);
    flush();

    // RAM -> SPI TX using reloaded count and pointer, stalled ready
    mem[32'h200] = 8'h5A; mem[32'h201] = 8'hC3; mem[32'h202] = 8'h99;
    wr(4'd0, 8'hF7);
    exp_ptr = 16'h0200;
    dst_allow = 5'b01000; ram_allow = 1'b1; stall = 1'b1;
    wr(4'd1, 8'h01);
    fire();
    wait_done("R6 RAM to SPI done");
    chk(expq.size() == 0, "R4 all bytes delivered", expq.size(), 0);
    expect_reg(4'd6, 8'h00, "R8 pointer reload after read block");
    wr(4'd1, 8'h02);
    flush();

    // ADC -> CRC, length one, one extra byte must stay
    setup(8'h9D, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000);
    src_allow = 5'b10000; dst_allow = 5'b10000;
    srcq[4].push_back(8'h77); srcq[4].push_back(8'h88);
    wr(4'd1, 8'h01);
    fire();
    wait_done("R6 single transaction done");
    repeat (4) @(negedge clk);
    chk(srcq[4].size() == 1, "R6 length one", srcq[4].size(), 1);
    wr(4'd1, 8'h02);
    flush();

    // trigger without arm
    setup(8'h11, 16'hFFFE, 16'hFFFE, 16'h0000, 16'h0000);
    srcq[0].push_back(8'h42);
    fire();
    repeat (6) @(negedge clk);
    expect_reg(4'd1, 8'h00, "R2 unarmed trigger ignored");
    chk(srcq[0].size() == 1, "R2 no byte taken", srcq[0].size(), 1);
    flush();

    // reserved source, disabled destination, RAM to RAM
    setup(8'hD1, 16'hFFF0, 16'h0000, 16'h0010, 16'h0000);
    wr(4'd1, 8'h01);
    fire(); repeat (6) @(negedge clk);
    expect_reg(4'd1, 8'h01, "R3 reserved source blocks start");
    expect_reg(4'd2, 8'hF0, "R3 count untouched");
    wr(4'd0, 8'h10);
    fire(); repeat (6) @(negedge clk);
    expect_reg(4'd1, 8'h01, "R3 disabled destination blocks start");
    wr(4'd0, 8'hFF);
    fire(); repeat (6) @(negedge clk);
    expect_reg(4'd1, 8'h01, "R3 RAM to RAM blocked");
    expect_reg(4'd6, 8'h10, "R3 pointer untouched");
    wr(4'd1, 8'h00);
    flush();

    // serial-1 RX -> two-wire TX, three bytes, both sides stalling
    setup(8'h25, 16'hFFFD, 16'h0000, 16'h0000, 16'h0000);
    src_allow = 5'b00010; dst_allow = 5'b00100; stall = 1'b1;
    srcq[1].push_back(8'h01); srcq[1].push_back(8'hFE); srcq[1].push_back(8'h3C);
    wr(4'd1, 8'h01);
    fire();
    wait_done("R4 peripheral to peripheral done");
    repeat (3) @(negedge clk);
    chk(srcq[1].size() == 0 && expq.size() == 0, "R4 three bytes delivered", srcq[1].size(), 0);
    expect_reg(4'd3, 8'h00, "R7 base reload to zero");
    wr(4'd1, 8'h02);
    flush();

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule